// File: doc/BRIEF.md
# Two-Tier Interrupt Aggregator

This block collects interrupt events for a small 8-bit processor core. Three core-level sources feed it: an external pin edge, a port-change detector and a timer-0 overflow. A configurable number of peripheral sources feed it as well. Each event is a single-cycle pulse. The pulse latches into a flag bit, and the flag stays set until software clears it. No enable setting stops a flag from latching.

A source can raise a request only when its own enable is set. A peripheral source also needs the peripheral group enable. All requests then pass through the global enable before they reach the CPU. When the CPU signals that it has taken an interrupt, the global enable clears, so nested entry is blocked. The CPU's return strobe sets the global enable again. The vector output carries the fixed service address at all times.

A wake output reports every enabled and pending source, whatever the state of the global enable, so a sleeping core can be woken while interrupts are globally off. The two external sources pass through a short delay line before they reach their flags. This delay models the synchronisation latency from the pin to the flag.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all three registers read 0x00, and `irq_req` and `wake` are both low.
- R2: An event pulse on any source sets that source's flag at the next clock edge, whatever the state of its enable, the group enable or the global enable.
- R3: A pin or port-change pulse sampled at edge k sets its flag at edge k+EXT_LAT. Timer-0 and peripheral pulses sampled at edge k set their flags at edge k.
- R4: Address 0 holds the core control register. Its bits are: bit 7 global enable, bit 6 peripheral group enable, bit 5 timer-0 enable, bit 4 pin enable, bit 3 port-change enable, bit 2 timer-0 flag, bit 1 pin flag, bit 0 port-change flag. `irq_req` is high when the global enable is set and any enabled source is pending.
- R5: While the global enable is clear, `irq_req` stays low, whatever the flags and the other enables.
- R6: A pulse on `irq_take` clears the global enable at the next edge. `vector` always reads VECTOR (default 0x0004).
- R7: A pulse on `irq_return` sets the global enable at the next edge. When `irq_take` is pulsed in the same cycle, `irq_take` wins and the global enable stays clear.
- R8: Taking an interrupt leaves every flag unchanged. A flag that is still set brings `irq_req` back once the global enable returns.
- R9: If a register write clears a flag in the same cycle as a new event for that flag, the flag ends up set.
- R10: `wake` is high when any enabled source is pending, whatever the state of the global enable.
- R11: A peripheral source counts as pending only when its flag, its enable (address 2, bit i) and the group enable are all set.
- R12: Address 1 holds the peripheral flags in bits NUM_PERIPH-1..0. Address 2 holds the matching peripheral enables. Unused bits, and the whole of address 3, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_evt | input | 1 | External pin edge event pulse |
| portchg_evt | input | 1 | Port-change event pulse |
| tmr0_evt | input | 1 | Timer-0 overflow event pulse |
| periph_evt | input | NUM_PERIPH | Peripheral event pulses, one bit per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_take | input | 1 | CPU acknowledges that it has taken an interrupt |
| irq_return | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the CPU |
| wake | output | 1 | Wake request for a sleeping core |
| vector | output | VEC_W | Fixed interrupt service address |

## Verification
The bench uses the defaults: five peripheral sources, EXT_LAT of 2, and a vector of 0x0004 on a 13-bit bus. With a two-stage delay, the bench can tell the delayed external path from the direct timer path by checking a pin flag that is still clear on two reads in a row and set on the third. With five peripheral bits, the bench can see the upper bits of the peripheral registers read back as zero after an all-ones write. It also drives same-cycle collisions, such as take with return, and a flag clear with a new event, so that the priority rules can be observed at the ports.

// File: rtl/irq_aggregator_pkg.sv
package irq_aggregator_pkg;
  localparam int REG_W   = 8;
  localparam int CORE_N  = 3;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] A_CORE  = 2'd0;
  localparam logic [ADDR_W-1:0] A_PFLAG = 2'd1;
  localparam logic [ADDR_W-1:0] A_PEN   = 2'd2;

  // core control register field positions
  localparam int B_GLOB  = 7;
  localparam int B_GROUP = 6;
  localparam int B_ENLO  = 3;
  localparam int B_FLGLO = 0;
endpackage

// File: rtl/irq_ext_delay.sv
module irq_ext_delay #(
  parameter int W     = 2,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_pipe
      logic [W-1:0] stage [DEPTH];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
          stage[0] <= din;
          for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
      end
      assign dout = stage[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flags
);
  // an event always beats a software write to the same bit
  function automatic logic [W-1:0] next_flags(logic [W-1:0] cur, logic [W-1:0] ev,
                                              logic we, logic [W-1:0] wd);
    return ev | (we ? wd : cur);
  endfunction

  logic [W-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= next_flags(flag_q, evt, wr, wdata);
  end

  assign flags = flag_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_chk
      assert_event_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> flag_q[i]);
      assert_event_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[i] && wr && !wdata[i]) |=> flag_q[i]);
      assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt[i] && !wr) |=> $stable(flag_q[i]));
    end
  endgenerate
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int NC = 3,
  parameter int NP = 5
) (
  input  logic [NC-1:0] core_flags,
  input  logic [NC-1:0] core_en,
  input  logic [NP-1:0] per_flags,
  input  logic [NP-1:0] per_en,
  input  logic          group_en,
  input  logic          glob_en,
  output logic          core_hit,
  output logic          per_hit,
  output logic          wake,
  output logic          req
);
  function automatic logic any_core(logic [NC-1:0] f, logic [NC-1:0] e);
    return |(f & e);
  endfunction

  function automatic logic any_per(logic [NP-1:0] f, logic [NP-1:0] e, logic g);
    return g & (|(f & e));
  endfunction

  assign core_hit = any_core(core_flags, core_en);
  assign per_hit  = any_per(per_flags, per_en, group_en);
  assign wake     = core_hit | per_hit;
  assign req      = glob_en & wake;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_aggregator_pkg::*;
#(
  parameter int              NUM_PERIPH = 5,
  parameter int              EXT_LAT    = 2,
  parameter int              VEC_W      = 13,
  parameter logic [VEC_W-1:0] VECTOR    = 13'h0004
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pin_evt,
  input  logic                  portchg_evt,
  input  logic                  tmr0_evt,
  input  logic [NUM_PERIPH-1:0] periph_evt,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic                  irq_take,
  input  logic                  irq_return,
  output logic                  irq_req,
  output logic                  wake,
  output logic [VEC_W-1:0]      vector
);
  localparam int EXT_N = 2;

  // named internal events
  logic [EXT_N-1:0]      ext_late;
  logic [CORE_N-1:0]     core_evt;
  logic [CORE_N-1:0]     core_flags;
  logic [CORE_N-1:0]     core_en_q;
  logic [NUM_PERIPH-1:0] per_flags;
  logic [NUM_PERIPH-1:0] per_en_q;
  logic                  group_q;
  logic                  glob_q;
  logic                  wr_core, wr_pflag, wr_pen;
  logic                  core_hit, per_hit;

  function automatic logic [REG_W-1:0] zext(logic [NUM_PERIPH-1:0] v);
    logic [REG_W-1:0] r;
    r = '0;
    r[NUM_PERIPH-1:0] = v;
    return r;
  endfunction

  assign wr_core  = reg_wr && (reg_addr == A_CORE);
  assign wr_pflag = reg_wr && (reg_addr == A_PFLAG);
  assign wr_pen   = reg_wr && (reg_addr == A_PEN);

  // bit0 port change, bit1 pin: delayed path
  irq_ext_delay #(.W(EXT_N), .DEPTH(EXT_LAT)) u_ext (
    .clk(clk), .rst_n(rst_n),
    .din({pin_evt, portchg_evt}),
    .dout(ext_late)
  );

  assign core_evt = {tmr0_evt, ext_late};

  irq_flag_bank #(.W(CORE_N)) u_core_flags (
    .clk(clk), .rst_n(rst_n), .evt(core_evt),
    .wr(wr_core), .wdata(reg_wdata[B_FLGLO +: CORE_N]),
    .flags(core_flags)
  );

  irq_flag_bank #(.W(NUM_PERIPH)) u_per_flags (
    .clk(clk), .rst_n(rst_n), .evt(periph_evt),
    .wr(wr_pflag), .wdata(reg_wdata[NUM_PERIPH-1:0]),
    .flags(per_flags)
  );

  // control bits; priority for global enable: take > return > write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_q    <= 1'b0;
      group_q   <= 1'b0;
      core_en_q <= '0;
      per_en_q  <= '0;
    end else begin
      if (wr_core) begin
        glob_q    <= reg_wdata[B_GLOB];
        group_q   <= reg_wdata[B_GROUP];
        core_en_q <= reg_wdata[B_ENLO +: CORE_N];
      end
      if (wr_pen) per_en_q <= reg_wdata[NUM_PERIPH-1:0];
      if (irq_return) glob_q <= 1'b1;
      if (irq_take)   glob_q <= 1'b0;
    end
  end

  irq_gate #(.NC(CORE_N), .NP(NUM_PERIPH)) u_gate (
    .core_flags(core_flags), .core_en(core_en_q),
    .per_flags(per_flags), .per_en(per_en_q),
    .group_en(group_q), .glob_en(glob_q),
    .core_hit(core_hit), .per_hit(per_hit),
    .wake(wake), .req(irq_req)
  );

  always_comb begin
    case (reg_addr)
      A_CORE:  reg_rdata = {glob_q, group_q, core_en_q, core_flags};
      A_PFLAG: reg_rdata = zext(per_flags);
      A_PEN:   reg_rdata = zext(per_en_q);
      default: reg_rdata = '0;
    endcase
  end

  assign vector = VECTOR;

  assert_take_clears_glob_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !glob_q);
  assert_return_sets_glob_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && !irq_take) |=> glob_q);
  assert_no_req_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_q |-> !irq_req);
  assert_req_implies_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wake);
  assert_group_gates_periph_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !group_q |-> !per_hit);
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int NP = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pin_evt = 1'b0, portchg_evt = 1'b0, tmr0_evt = 1'b0;
  logic [NP-1:0] periph_evt = '0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [7:0]    reg_wdata = 8'h00;
  logic [7:0]    reg_rdata;
  logic          irq_take = 1'b0, irq_return = 1'b0;
  logic          irq_req, wake;
  logic [12:0]   vector;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic [1:0] addr;
    logic [7:0] data;
    logic       req;
    logic       wk;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst_n(rst_n),
    .pin_evt(pin_evt), .portchg_evt(portchg_evt), .tmr0_evt(tmr0_evt),
    .periph_evt(periph_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq_take(irq_take), .irq_return(irq_return),
    .irq_req(irq_req), .wake(wake), .vector(vector)
  );

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (reg_rdata !== e.data || irq_req !== e.req || wake !== e.wk ||
            vector !== 13'h0004) begin
          errors++;
          $display("FAIL %s: addr=%0d rdata=%h/%h req=%b/%b wake=%b/%b vector=%h/0004",
                   e.tag, e.addr, reg_rdata, e.data, irq_req, e.req, wake, e.wk, vector);
        end
      end
    end
  end

  // driver tasks: called at a falling edge, return at a falling edge
  task automatic expect_obs(string tag, logic [1:0] a, logic [7:0] d, logic rq, logic wk);
    exp_t e;
    reg_addr = a;
    e.tag = tag; e.addr = a; e.data = d; e.req = rq; e.wk = wk;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic write_reg(logic [1:0] a, logic [7:0] d, logic [NP-1:0] pev = '0);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; periph_evt = pev;
    @(negedge clk);
    reg_wr = 1'b0; periph_evt = '0;
  endtask

  task automatic pulse(logic p, logic c, logic t, logic [NP-1:0] pv);
    pin_evt = p; portchg_evt = c; tmr0_evt = t; periph_evt = pv;
    @(negedge clk);
    pin_evt = 0; portchg_evt = 0; tmr0_evt = 0; periph_evt = '0;
  endtask

  task automatic ctl(logic tk, logic rt);
    irq_take = tk; irq_return = rt;
    @(negedge clk);
    irq_take = 0; irq_return = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_obs("R1 core reg", 2'd0, 8'h00, 0, 0);
    expect_obs("R1 pflag reg", 2'd1, 8'h00, 0, 0);
    expect_obs("R1 pen reg", 2'd2, 8'h00, 0, 0);

    // R2 flags latch with all enables off; timer paths are direct (R3)
    pulse(0, 0, 1, '0);
    expect_obs("R2 R3 timer0 flag direct", 2'd0, 8'h04, 0, 0);
    pulse(0, 0, 0, 5'h11);
    expect_obs("R2 periph flags", 2'd1, 8'h11, 0, 0);

    // R3 pin event: delayed by two edges
    pulse(1, 0, 0, '0);
    expect_obs("R3 pin not yet (1)", 2'd0, 8'h04, 0, 0);
    expect_obs("R3 pin not yet (2)", 2'd0, 8'h04, 0, 0);
    expect_obs("R3 pin flag arrives", 2'd0, 8'h06, 0, 0);

    // R10 wake without global enable
    write_reg(2'd0, 8'h26);
    expect_obs("R10 wake with global off", 2'd0, 8'h26, 0, 1);
    // R4 request once global enable set
    write_reg(2'd0, 8'hA6);
    expect_obs("R4 request asserted", 2'd0, 8'hA6, 1, 1);

    // R6 take clears global, R8 flags kept
    ctl(1, 0);
    expect_obs("R6 R8 take clears global only", 2'd0, 8'h26, 0, 1);
    // R7 take beats return
    ctl(1, 1);
    expect_obs("R7 take wins over return", 2'd0, 8'h26, 0, 1);
    // R7 return restores, R8 request reasserts
    ctl(0, 1);
    expect_obs("R7 R8 return re-requests", 2'd0, 8'hA6, 1, 1);

    write_reg(2'd0, 8'hA0);
    expect_obs("R4 flags cleared, no request", 2'd0, 8'hA0, 0, 0);

    // R11 peripheral needs group enable
    write_reg(2'd2, 8'h01);
    expect_obs("R11 group off blocks periph", 2'd2, 8'h01, 0, 0);
    write_reg(2'd0, 8'hE0);
    expect_obs("R11 group on allows periph", 2'd0, 8'hE0, 1, 1);

    // R9 clear collides with new event on bit 4
    write_reg(2'd1, 8'h00, 5'h10);
    expect_obs("R9 event beats clear", 2'd1, 8'h10, 0, 0);

    // R5 global off: pending source gives wake but no request
    write_reg(2'd0, 8'h60);
    pulse(0, 0, 0, 5'h01);
    expect_obs("R5 no request with global off", 2'd1, 8'h11, 0, 1);

    // R12 unused bits and address 3
    expect_obs("R12 address 3 reads zero", 2'd3, 8'h00, 0, 1);
    write_reg(2'd1, 8'hFF);
    expect_obs("R12 pflag upper bits zero", 2'd1, 8'h1F, 0, 1);
    write_reg(2'd2, 8'hE0);
    expect_obs("R12 pen upper bits zero", 2'd2, 8'h00, 0, 0);

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule